// File: doc/BRIEF.md
# Multi-Channel DMA Configuration Register Decoder

This block is the configuration side of a multi-channel DMA controller. A processor reaches it through a simple request/response target bus of 32-bit single-word accesses. It decodes a channel number and a register number from each address. For every channel it keeps the source pointer, the destination pointer and an interrupt-mask word. Writing a byte count to a channel's length register launches that channel's transfer engine with a one-cycle start pulse. Reading the same register returns the engine's current status code.

Each channel also has a write-only reset register. A write to it sends a one-cycle reset pulse to the engine and clears the channel's pending completion interrupt. The transfer engines are not part of this block. Each one is seen only through a 3-bit status input, and the block turns that status into a per-channel completion flag and interrupt line. An access that lands outside the block's 32 KB segment, or names a channel that was not built, gets an error response and changes nothing.

The top module is parameterised by the number of channels (1 to 8) and by the segment base address, which must be 32 KB aligned. Every request gets exactly one response on the following cycle, and there is no back-pressure.

Top module: `dma_cfg_regs`

## Requirements
- R1: After reset, every source, destination and mask register reads zero. All start and reset pulses and rspValid are low, irqEnable is all ones and irqOut is all zeros.
- R2: A request accepted on one clock edge produces rspValid high for exactly one cycle after that edge, with rspData and rspErr valid in that cycle.
- R3: The channel index is address bits [14:12] and the register offset is address bits [4:0]. Offset 0x00 holds the source address and 0x04 the destination address, both read/write per channel and driven on srcAddr/dstAddr. Address bits [11:5] are not decoded.
- R4: A write to offset 0x08 raises startPulse for that channel alone for one cycle after the request edge, with startLen equal to the written byte count.
- R5: A read of offset 0x08 returns that channel's 3-bit chanStatus input, zero-extended. The codes are 0 success, 1 read error, 2 idle, 3 write error, and 4 to 7 busy.
- R6: A write of any value to offset 0x0C raises chanReset for that channel alone for one cycle and clears its completion flag. A read of 0x0C returns zero.
- R7: Offset 0x10 is a read/write mask word. A nonzero value drives irqEnable low for that channel and forces its irqOut low; zero re-enables it.
- R8: A channel's completion flag is set on the edge after its status changes from any other code to 0, 1 or 3. irqOut is that flag gated by irqEnable.
- R9: An address whose bits [31:15] differ from the segment base, or whose channel index is at or above NUM_CH, gets rspErr high and rspData zero. Such an access causes no pulse and no register change.
- R10: A read of any other offset returns zero, and a write to one has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response present |
| rspData | output | 32 | Read data (zero for writes and errors) |
| rspErr | output | 1 | Segment or channel error |
| chanStatus | input | NUM_CH*3 | Engine status per channel, channel k at bits [3k+2:3k] |
| srcAddr | output | NUM_CH*32 | Source pointer per channel |
| dstAddr | output | NUM_CH*32 | Destination pointer per channel |
| startPulse | output | NUM_CH | One-cycle start per channel |
| startLen | output | 32 | Byte count for the channel being started |
| chanReset | output | NUM_CH | One-cycle clean reset per channel |
| irqEnable | output | NUM_CH | High when the channel's mask word is zero |
| irqOut | output | NUM_CH | Completion interrupt per channel |

## Verification
The bench builds the block with six channels and a segment base of 0x0004_8000. With six channels, indexes 6 and 7 can be encoded in address bits [14:12] yet must be refused, so the channel-limit error path is reachable next to the out-of-segment path. The nonzero base puts an alias of channel 0 one segment higher, where it has to be rejected. The six channels are given six different status codes at once, so every code class is read back and completion flags are raised on several channels together. That lets the reset and mask tests show they touch only their own channel.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;
  localparam int DATA_W = 32;
  localparam int CH_IDX_W = 3;
  localparam int ST_W = 3;

  typedef enum logic [2:0] {
    SEL_SRC,
    SEL_DST,
    SEL_LEN,
    SEL_RST,
    SEL_MASK,
    SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic rdEn;
    logic wrSrc;
    logic wrDst;
    logic wrLen;
    logic wrRst;
    logic wrMask;
    logic accErr;
    regSel_e sel;
    logic [CH_IDX_W-1:0] ch;
  } cfgStrobe_t;
endpackage

// File: rtl/dma_cfg_ctrl.sv
module dma_cfg_ctrl
  import dma_cfg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter logic [31:0] SEG_BASE = 32'h0000_0000
) (
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  output cfgStrobe_t  strobe
);
  localparam int SEG_LSB = 15;
  localparam logic [CH_IDX_W:0] CH_LIM = (CH_IDX_W+1)'(NUM_CH);

  logic inSeg;
  logic chOk;
  logic hit;
  regSel_e sel;

  always_comb begin
    inSeg = (reqAddr[31:SEG_LSB] == SEG_BASE[31:SEG_LSB]);
    chOk  = ({1'b0, reqAddr[14:12]} < CH_LIM);
    hit   = reqValid && inSeg && chOk;
    unique case (reqAddr[4:0])
      5'h00:   sel = SEL_SRC;
      5'h04:   sel = SEL_DST;
      5'h08:   sel = SEL_LEN;
      5'h0C:   sel = SEL_RST;
      5'h10:   sel = SEL_MASK;
      default: sel = SEL_NONE;
    endcase
    strobe.rdEn   = hit && !reqWrite;
    strobe.wrSrc  = hit && reqWrite && (sel == SEL_SRC);
    strobe.wrDst  = hit && reqWrite && (sel == SEL_DST);
    strobe.wrLen  = hit && reqWrite && (sel == SEL_LEN);
    strobe.wrRst  = hit && reqWrite && (sel == SEL_RST);
    strobe.wrMask = hit && reqWrite && (sel == SEL_MASK);
    strobe.accErr = reqValid && !(inSeg && chOk);
    strobe.sel    = sel;
    strobe.ch     = reqAddr[14:12];
  end
endmodule

// File: rtl/dma_cfg_dpath.sv
module dma_cfg_dpath
  import dma_cfg_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [DATA_W-1:0]        reqWdata,
  input  cfgStrobe_t               strobe,
  input  logic [NUM_CH*ST_W-1:0]   chanStatus,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData,
  output logic                     rspErr,
  output logic [NUM_CH*DATA_W-1:0] srcAddr,
  output logic [NUM_CH*DATA_W-1:0] dstAddr,
  output logic [NUM_CH-1:0]        startPulse,
  output logic [DATA_W-1:0]        startLen,
  output logic [NUM_CH-1:0]        chanReset,
  output logic [NUM_CH-1:0]        irqEnable,
  output logic [NUM_CH-1:0]        irqOut
);
  logic [NUM_CH*DATA_W-1:0] maskFlat;
  logic [DATA_W-1:0] rdNext;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [DATA_W-1:0] srcReg, dstReg, maskReg;
    logic doneFlag, prevTerm, termNow, selMe;
    logic [ST_W-1:0] st;

    assign st      = chanStatus[g*ST_W +: ST_W];
    assign termNow = (st == 3'd0) || (st == 3'd1) || (st == 3'd3);
    assign selMe   = (strobe.ch == CH_IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcReg        <= '0;
        dstReg        <= '0;
        maskReg       <= '0;
        doneFlag      <= 1'b0;
        prevTerm      <= 1'b0;
        startPulse[g] <= 1'b0;
        chanReset[g]  <= 1'b0;
      end else begin
        if (strobe.wrSrc && selMe)  srcReg  <= reqWdata;
        if (strobe.wrDst && selMe)  dstReg  <= reqWdata;
        if (strobe.wrMask && selMe) maskReg <= reqWdata;
        prevTerm      <= termNow;
        startPulse[g] <= strobe.wrLen && selMe;
        chanReset[g]  <= strobe.wrRst && selMe;
        if (strobe.wrRst && selMe)      doneFlag <= 1'b0;
        else if (termNow && !prevTerm)  doneFlag <= 1'b1;
      end
    end

    assign srcAddr[g*DATA_W +: DATA_W]  = srcReg;
    assign dstAddr[g*DATA_W +: DATA_W]  = dstReg;
    assign maskFlat[g*DATA_W +: DATA_W] = maskReg;
    assign irqEnable[g] = (maskReg == '0);
    assign irqOut[g]    = doneFlag && irqEnable[g];
  end

  always_comb begin
    rdNext = '0;
    if (strobe.rdEn) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (strobe.ch == CH_IDX_W'(i)) begin
          unique case (strobe.sel)
            SEL_SRC:  rdNext = srcAddr[i*DATA_W +: DATA_W];
            SEL_DST:  rdNext = dstAddr[i*DATA_W +: DATA_W];
            SEL_LEN:  rdNext = {{(DATA_W-ST_W){1'b0}}, chanStatus[i*ST_W +: ST_W]};
            SEL_MASK: rdNext = maskFlat[i*DATA_W +: DATA_W];
            default:  rdNext = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      rspErr   <= 1'b0;
      startLen <= '0;
    end else begin
      rspValid <= reqValid;
      rspData  <= rdNext;
      rspErr   <= strobe.accErr;
      if (strobe.wrLen) startLen <= reqWdata;
    end
  end
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_cfg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter logic [31:0] SEG_BASE = 32'h0000_0000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [31:0]            reqAddr,
  input  logic [31:0]            reqWdata,
  output logic                   rspValid,
  output logic [31:0]            rspData,
  output logic                   rspErr,
  input  logic [NUM_CH*3-1:0]    chanStatus,
  output logic [NUM_CH*32-1:0]   srcAddr,
  output logic [NUM_CH*32-1:0]   dstAddr,
  output logic [NUM_CH-1:0]      startPulse,
  output logic [31:0]            startLen,
  output logic [NUM_CH-1:0]      chanReset,
  output logic [NUM_CH-1:0]      irqEnable,
  output logic [NUM_CH-1:0]      irqOut
);
  cfgStrobe_t strobe;

  dma_cfg_ctrl #(.NUM_CH(NUM_CH), .SEG_BASE(SEG_BASE)) uCtrl (
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .strobe  (strobe)
  );

  dma_cfg_dpath #(.NUM_CH(NUM_CH)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWdata  (reqWdata),
    .strobe    (strobe),
    .chanStatus(chanStatus),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .rspErr    (rspErr),
    .srcAddr   (srcAddr),
    .dstAddr   (dstAddr),
    .startPulse(startPulse),
    .startLen  (startLen),
    .chanReset (chanReset),
    .irqEnable (irqEnable),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/dma_cfg_regs_chk.sv
module dma_cfg_regs_chk #(
  parameter int NUM_CH = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqWrite,
  input logic [31:0]          reqAddr,
  input logic [31:0]          reqWdata,
  input logic                 rspValid,
  input logic [31:0]          rspData,
  input logic                 rspErr,
  input logic [NUM_CH*3-1:0]  chanStatus,
  input logic [NUM_CH*32-1:0] srcAddr,
  input logic [NUM_CH*32-1:0] dstAddr,
  input logic [NUM_CH-1:0]    startPulse,
  input logic [31:0]          startLen,
  input logic [NUM_CH-1:0]    chanReset,
  input logic [NUM_CH-1:0]    irqEnable,
  input logic [NUM_CH-1:0]    irqOut
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(reqValid)); // R2
  AST_ERR_HAS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid); // R2
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(startPulse)); // R4
  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|startPulse) |-> ($past(reqValid && reqWrite) && rspValid && !rspErr)); // R4
  AST_RESET_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanReset)); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (startPulse == '0 && chanReset == '0 && rspData == '0)); // R9

  for (genvar i = 0; i < NUM_CH; i++) begin : gChk
    AST_RESET_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
      chanReset[i] |-> !irqOut[i]); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[i] |-> irqEnable[i]); // R7
  end
endmodule

bind dma_cfg_regs dma_cfg_regs_chk #(.NUM_CH(NUM_CH)) uChk (.*);

// File: tb/sim_dma_cfg_regs.sv
`timescale 1ns/1ps
module sim_dma_cfg_regs;
  localparam int NCH = 6;
  localparam logic [31:0] BASE = 32'h0004_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic rspValid, rspErr;
  logic [31:0] rspData, startLen;
  logic [NCH*3-1:0] chanStatus = {NCH{3'd2}};
  logic [NCH*32-1:0] srcAddr, dstAddr;
  logic [NCH-1:0] startPulse, chanReset, irqEnable, irqOut;

  dma_cfg_regs #(.NUM_CH(NCH), .SEG_BASE(BASE)) u0 (.*);

  always #2.5 clk = ~clk;

  int nChk = 0, nBad = 0;
  logic [31:0] qData[$];
  logic qErr[$];
  string qTag[$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected response and compare
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (qData.size() == 0) begin
        nChk++; nBad++;
        $display("FAIL R2 unexpected response actual=%h expected=none", rspData);
      end else begin
        logic [31:0] d;
        logic e;
        string t;
        d = qData.pop_front(); e = qErr.pop_front(); t = qTag.pop_front();
        chk(t, {31'b0, rspErr, rspData}, {31'b0, e, d});
      end
    end
  end

  function automatic logic [31:0] adr(int ch, logic [11:0] off);
    return BASE + 32'(ch << 12) + {20'b0, off};
  endfunction

  task automatic acc(bit wr, logic [31:0] a, logic [31:0] wd,
                     logic [31:0] expD, bit expE, string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    qData.push_back(expD); qErr.push_back(expE); qTag.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  endtask

  initial begin
    #500000;
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rspValid", 64'(rspValid), 64'd0);
    chk("R1 startPulse/chanReset", 64'({startPulse, chanReset}), 64'd0);
    chk("R1 irqEnable", 64'(irqEnable), 64'h3F);
    chk("R1 irqOut", 64'(irqOut), 64'd0);
    chk("R1 srcAddr", 64'(srcAddr[63:0]), 64'd0);
    acc(0, adr(2, 12'h010), 0, 32'd0, 0, "R1 mask reads zero");

    // R3 per-channel source/destination
    for (int c = 0; c < NCH; c++) begin
      acc(1, adr(c, 12'h000), 32'h1000_0000 + 32'(c * 256), 0, 0, "R3 wr src");
      acc(1, adr(c, 12'h004), 32'h2000_0000 + 32'(c * 64), 0, 0, "R3 wr dst");
    end
    for (int c = 0; c < NCH; c++) begin
      acc(0, adr(c, 12'h000), 0, 32'h1000_0000 + 32'(c * 256), 0, "R3 rd src");
      acc(0, adr(c, 12'h004), 0, 32'h2000_0000 + 32'(c * 64), 0, "R3 rd dst");
    end
    chk("R3 srcAddr port ch4", 64'(srcAddr[4*32 +: 32]), 64'h1000_0400);
    chk("R3 dstAddr port ch5", 64'(dstAddr[5*32 +: 32]), 64'h2000_0140);
    acc(1, adr(1, 12'h7E0), 32'hCAFE_0000, 0, 0, "R3 undecoded bits wr");
    acc(0, adr(1, 12'h000), 0, 32'hCAFE_0000, 0, "R3 undecoded bits rd");

    // R4 length write starts channel
    acc(1, adr(3, 12'h008), 32'h0000_0200, 0, 0, "R4 wr len");
    chk("R4 startPulse", 64'(startPulse), 64'b001000);
    chk("R4 startLen", 64'(startLen), 64'h200);
    @(negedge clk);
    chk("R4 pulse one cycle", 64'(startPulse), 64'd0);

    // R10 unmapped offsets, R6 reset reg reads zero
    acc(0, adr(0, 12'h014), 0, 32'd0, 0, "R10 rd unmapped");
    acc(1, adr(0, 12'h018), 32'hFFFF_FFFF, 0, 0, "R10 wr unmapped");
    acc(0, adr(0, 12'h000), 0, 32'h1000_0000, 0, "R10 src unchanged");
    chk("R10 no pulse", 64'({startPulse, chanReset}), 64'd0);
    acc(0, adr(0, 12'h00C), 0, 32'd0, 0, "R6 rd reset reg zero");

    // R9 errors
    acc(1, BASE + 32'h8000, 32'hDEAD_BEEF, 0, 1, "R9 out of segment wr");
    acc(1, BASE + 32'h8008, 32'h40, 0, 1, "R9 out of segment len");
    chk("R9 no start", 64'(startPulse), 64'd0);
    acc(1, adr(6, 12'h000), 32'h1234_5678, 0, 1, "R9 channel 6 wr");
    acc(0, adr(7, 12'h008), 0, 32'd0, 1, "R9 channel 7 rd");
    acc(0, adr(0, 12'h000), 0, 32'h1000_0000, 0, "R9 ch0 unchanged");

    // R5 status reads, R8 completion flags
    @(negedge clk);
    chanStatus = {3'd7, 3'd4, 3'd3, 3'd1, 3'd0, 3'd2};
    acc(0, adr(0, 12'h008), 0, 32'd2, 0, "R5 idle");
    acc(0, adr(1, 12'h008), 0, 32'd0, 0, "R5 success");
    acc(0, adr(2, 12'h008), 0, 32'd1, 0, "R5 read error");
    acc(0, adr(3, 12'h008), 0, 32'd3, 0, "R5 write error");
    acc(0, adr(4, 12'h008), 0, 32'd4, 0, "R5 busy 4");
    acc(0, adr(5, 12'h008), 0, 32'd7, 0, "R5 busy 7");
    chk("R8 irqOut set", 64'(irqOut), 64'b001110);

    // R6 reset pulse clears flag
    acc(1, adr(1, 12'h00C), 32'd0, 0, 0, "R6 wr reset");
    chk("R6 chanReset", 64'(chanReset), 64'b000010);
    chk("R6 irq cleared", 64'(irqOut), 64'b001100);
    @(negedge clk);
    chk("R6 pulse one cycle", 64'(chanReset), 64'd0);
    chk("R6 stays cleared", 64'(irqOut), 64'b001100);

    // R7 masking
    acc(1, adr(3, 12'h010), 32'd5, 0, 0, "R7 wr mask");
    chk("R7 irqEnable", 64'(irqEnable), 64'b110111);
    chk("R7 irqOut masked", 64'(irqOut), 64'b000100);
    acc(0, adr(3, 12'h010), 0, 32'd5, 0, "R7 rd mask");
    acc(1, adr(3, 12'h010), 32'd0, 0, 0, "R7 unmask");
    chk("R7 irqOut restored", 64'(irqOut), 64'b001100);

    // R8 busy to success transition
    chanStatus[4*3 +: 3] = 3'd0;
    @(negedge clk);
    chk("R8 new completion", 64'(irqOut), 64'b011100);

    repeat (2) @(negedge clk);
    chk("R2 all responses seen", 64'(qData.size()), 64'd0);
    finish_run();
  end
endmodule